// File: doc/BRIEF.md
# Nested Interrupt Acceptance Controller

This block sits next to a processor's interrupt sequencer. It decides whether a pending interrupt request may break into the code that is running now. That code may be the main program or a handler that is already active. The block keeps one pending flag for each maskable source and one for the non-maskable source. It weighs those flags against the processor's global enable flag, its in-service priority flag and the class of the handler in progress. When a request is accepted, the block raises a one-cycle acknowledge pulse together with the winning source index and its class.

Each maskable source has two controls. A mask bit blocks it. A programmable priority bit places it in the high level (0) or the low level (1). Within one level the lowest source index wins.

A request that is refused is not dropped. It stays pending until the rules allow it. After a handler returns to the main program, nothing is accepted until the processor reports that one main-program instruction has retired. Stacking, vectoring and the clearing of the enable flag on acknowledge are left to the processor.

Top module: `ic_nest_ctrl`

## Requirements
- R1: `ack_o` is high for exactly one cycle per acceptance and never in two consecutive cycles. The accepted source's pending flag is cleared, so the same request is not acknowledged twice. After reset `ack_o` is 0.
- R2: With handler class 00 (none), a pending unmasked maskable source is acknowledged only while `ie_i` is 1. A source whose `mask_i` bit is 1 is never acknowledged. A request refused for either reason stays pending and is acknowledged once the condition clears.
- R3: The pending non-maskable request wins over every maskable one. A maskable source with `prio_i` bit 0 wins over one with bit 1. Within the same level, the lowest index wins.
- R4: While `svc_class_i` is 11 (non-maskable handler), no request of any kind is acknowledged.
- R5: While `svc_class_i` is 01 (maskable handler) and `isp_i` is 0, a non-maskable request is accepted, a `prio_i`=0 source is accepted only when `ie_i` is 1, and a `prio_i`=1 source is refused.
- R6: While `svc_class_i` is 10 (software handler), or is 01 with `isp_i` = 1, a non-maskable request is accepted and any unmasked maskable source is accepted when `ie_i` is 1.
- R7: A change of `svc_class_i` from a nonzero value to 00 blocks every acknowledge. The block lasts until `retire_i` is seen high, in a cycle after the change, while the class is still 00. Acknowledging resumes from the cycle that follows.
- R8: An acknowledge reports `ack_cls_o` = 01 with `ack_id_o` equal to the source index for a maskable source, and `ack_cls_o` = 11 with `ack_id_o` = 0 for the non-maskable request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_set_i | input | N | One-cycle pulses that set per-source pending flags |
| mask_i | input | N | Per-source mask, 1 blocks the source |
| prio_i | input | N | Per-source level, 0 high, 1 low |
| nmi_set_i | input | 1 | One-cycle pulse that sets the non-maskable pending flag |
| ie_i | input | 1 | Global enable flag of the processor |
| isp_i | input | 1 | In-service priority flag, 0 when a high-level handler runs |
| svc_class_i | input | 2 | Active handler: 00 none, 01 maskable, 10 software, 11 non-maskable |
| retire_i | input | 1 | Pulse when one instruction has retired |
| ack_o | output | 1 | Acknowledge pulse |
| ack_id_o | output | IW | Index of the acknowledged source |
| ack_cls_o | output | 2 | Class of the acknowledged request |

## Verification
The assertions take for granted that the processor keeps `svc_class_i`, `ie_i` and `isp_i` consistent with its own acknowledge handling, and that `retire_i` only signals real instruction retirement. They also take for granted that `mask_i` and `prio_i` stay steady while a decision is made. The stimulus changes these control inputs only on the falling edge and only between scenarios, once every expected acknowledge has drained. Request pulses last exactly one cycle, and the handler class and flags are set before the requests that they are meant to govern.

// File: rtl/ic_pkg.sv
package ic_pkg;
    typedef enum logic [1:0] {
        CLS_NONE = 2'b00,
        CLS_MASK = 2'b01,
        CLS_SOFT = 2'b10,
        CLS_NMI  = 2'b11
    } cls_e;
endpackage

// File: rtl/ic_pend.sv
module ic_pend #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_d, pend_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_comb begin
            pend_d[g] = set_i[g] | (pend_q[g] & ~clr_i[g]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/ic_pick.sv
module ic_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = |vec_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/ic_nest_ctrl.sv
module ic_nest_ctrl
    import ic_pkg::*;
#(
    parameter  int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_set_i,
    input  logic [N-1:0]  mask_i,
    input  logic [N-1:0]  prio_i,
    input  logic          nmi_set_i,
    input  logic          ie_i,
    input  logic          isp_i,
    input  logic [1:0]    svc_class_i,
    input  logic          retire_i,
    output logic          ack_o,
    output logic [IW-1:0] ack_id_o,
    output logic [1:0]    ack_cls_o
);
    typedef struct packed {
        logic          ack;
        logic [IW-1:0] id;
        cls_e          cls;
        logic          nmi;
        logic          hold;
        cls_e          cls_prev;
    } state_t;

    state_t d, q;

    logic [N-1:0]  pend, clr_vec, elig, hi_vec, lo_vec;
    logic          hi_f, lo_f;
    logic [IW-1:0] hi_idx, lo_idx;
    logic          nmi_ok, hi_ok, lo_ok, returning, blocked;
    cls_e          svc;

    assign svc    = cls_e'(svc_class_i);
    assign elig   = pend & ~mask_i;
    assign hi_vec = elig & ~prio_i;
    assign lo_vec = elig & prio_i;

    ic_pend #(.N(N)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (req_set_i),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    ic_pick #(.N(N), .IW(IW)) u_pick_hi (
        .vec_i   (hi_vec),
        .found_o (hi_f),
        .idx_o   (hi_idx)
    );

    ic_pick #(.N(N), .IW(IW)) u_pick_lo (
        .vec_i   (lo_vec),
        .found_o (lo_f),
        .idx_o   (lo_idx)
    );

    // acceptance row selected by handler class and in-service flag
    always_comb begin
        unique case (svc)
            CLS_NONE: begin nmi_ok = 1'b1; hi_ok = ie_i; lo_ok = ie_i;          end
            CLS_MASK: begin nmi_ok = 1'b1; hi_ok = ie_i; lo_ok = ie_i & isp_i;  end
            CLS_SOFT: begin nmi_ok = 1'b1; hi_ok = ie_i; lo_ok = ie_i;          end
            default:  begin nmi_ok = 1'b0; hi_ok = 1'b0; lo_ok = 1'b0;          end
        endcase
    end

    assign returning = (q.cls_prev != CLS_NONE) && (svc == CLS_NONE);
    assign blocked   = q.ack | returning | (q.hold && (svc == CLS_NONE));

    always_comb begin
        d          = q;
        d.ack      = 1'b0;
        d.id       = '0;
        d.cls      = CLS_NONE;
        d.cls_prev = svc;
        clr_vec    = '0;

        if (returning) begin
            d.hold = 1'b1;
        end else if (q.hold && (svc == CLS_NONE) && retire_i) begin
            d.hold = 1'b0;
        end

        if (!blocked) begin
            if (nmi_ok && q.nmi) begin
                d.ack = 1'b1;
                d.cls = CLS_NMI;
                d.nmi = 1'b0;
            end else if (hi_ok && hi_f) begin
                d.ack   = 1'b1;
                d.id    = hi_idx;
                d.cls   = CLS_MASK;
                clr_vec = N'(1) << hi_idx;
            end else if (lo_ok && lo_f) begin
                d.ack   = 1'b1;
                d.id    = lo_idx;
                d.cls   = CLS_MASK;
                clr_vec = N'(1) << lo_idx;
            end
        end

        if (nmi_set_i) d.nmi = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ack: 1'b0, id: '0, cls: CLS_NONE, nmi: 1'b0,
                   hold: 1'b0, cls_prev: CLS_NONE};
        end else begin
            q <= d;
        end
    end

    assign ack_o     = q.ack;
    assign ack_id_o  = q.id;
    assign ack_cls_o = q.cls;
endmodule

// File: rtl/ic_nest_chk.sv
module ic_nest_chk #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  mask_i,
    input logic [N-1:0]  prio_i,
    input logic          ie_i,
    input logic          isp_i,
    input logic [1:0]    svc_class_i,
    input logic          ack_o,
    input logic [IW-1:0] ack_id_o,
    input logic [1:0]    ack_cls_o
);
    // R1
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R4
    nmi_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_class_i == 2'b11) |=> !ack_o);

    // R2
    ie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_i) |=> !(ack_o && ack_cls_o == 2'b01));

    // R2
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && ack_cls_o == 2'b01) |-> ((($past(mask_i) >> ack_id_o) & N'(1)) == '0));

    // R5
    isp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && ack_cls_o == 2'b01 && $past(svc_class_i) == 2'b01 && !$past(isp_i))
        |-> ((($past(prio_i) >> ack_id_o) & N'(1)) == '0));

    // R7
    return_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_class_i == 2'b00 && $past(svc_class_i) != 2'b00) |=> !ack_o);
endmodule

bind ic_nest_ctrl ic_nest_chk #(.N(N), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_i      (mask_i),
    .prio_i      (prio_i),
    .ie_i        (ie_i),
    .isp_i       (isp_i),
    .svc_class_i (svc_class_i),
    .ack_o       (ack_o),
    .ack_id_o    (ack_id_o),
    .ack_cls_o   (ack_cls_o)
);

// File: tb/ic_nest_ctrl_bench.sv
module ic_nest_ctrl_bench;
    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_set = '0, mask = '0;
    logic [N-1:0]  prio = 8'b1010_1100;
    logic          nmi_set = 1'b0, ie = 1'b0, isp = 1'b0, retire = 1'b0;
    logic [1:0]    svc = 2'b00;
    logic          ack;
    logic [IW-1:0] ack_id;
    logic [1:0]    ack_cls;

    int checks = 0;
    int errors = 0;
    int stray  = 0;
    logic [IW+1:0] exp_q[$];
    string tag_q[$];

    always #2.5ns clk = ~clk;

    ic_nest_ctrl #(.N(N)) u_ic_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .req_set_i(req_set), .mask_i(mask),
        .prio_i(prio), .nmi_set_i(nmi_set), .ie_i(ie), .isp_i(isp),
        .svc_class_i(svc), .retire_i(retire), .ack_o(ack),
        .ack_id_o(ack_id), .ack_cls_o(ack_cls)
    );

    // monitor: pops expected acknowledges in order
    always @(negedge clk) begin
        if (rst_n && ack) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                stray++;
                $display("FAIL R1 unexpected ack: actual id=%0d cls=%0d expected none",
                         ack_id, ack_cls);
            end else begin
                logic [IW+1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({ack_cls, ack_id} !== e) begin
                    errors++;
                    $display("FAIL %s ack: actual cls=%0d id=%0d expected cls=%0d id=%0d",
                             t, ack_cls, ack_id, e[IW+1:IW], e[IW-1:0]);
                end
            end
        end
    end

    task automatic push(input int id, input logic [1:0] cls, input string t);
        exp_q.push_back({cls, IW'(id)});
        tag_q.push_back(t);
    endtask

    task automatic pulse(input logic [N-1:0] bits, input logic nmi);
        @(negedge clk);
        req_set = bits;
        nmi_set = nmi;
        @(negedge clk);
        req_set = '0;
        nmi_set = 1'b0;
    endtask

    task automatic retire_one();
        @(negedge clk);
        retire = 1'b1;
        @(negedge clk);
        retire = 1'b0;
    endtask

    task automatic drain(input string t);
        for (int i = 0; i < 30 && exp_q.size() != 0; i++) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing ack: actual pending=%0d expected 0", t, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic quiet(input int n, input string t);
        int s0;
        s0 = stray;
        repeat (n) @(negedge clk);
        checks++;
        if (stray != s0) begin
            errors++;
            $display("FAIL %s refused request acked: actual %0d expected 0", t, stray - s0);
        end
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (ack !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual ack=%b expected 0", ack);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R8: idle, enabled, low-level source accepted once
        ie = 1'b1;
        push(5, 2'b01, "R2");
        pulse(8'h20, 1'b0);
        drain("R2");
        quiet(3, "R1");

        // R3: level first, then lowest index
        push(4, 2'b01, "R3");
        push(6, 2'b01, "R3");
        push(2, 2'b01, "R3");
        pulse(8'h54, 1'b0);
        drain("R3");

        // R2: enable low keeps request pending
        ie = 1'b0;
        pulse(8'h08, 1'b0);
        quiet(5, "R2");
        push(3, 2'b01, "R2");
        ie = 1'b1;
        drain("R2");

        // R2: masked source held
        mask = 8'h02;
        pulse(8'h02, 1'b0);
        quiet(5, "R2");
        push(1, 2'b01, "R2");
        mask = '0;
        drain("R2");

        // R4 then R7 with R3/R8 ordering
        svc = 2'b11;
        pulse(8'h01, 1'b1);
        quiet(5, "R4");
        svc = 2'b00;
        quiet(4, "R7");
        push(0, 2'b11, "R8");
        push(0, 2'b01, "R3");
        retire_one();
        drain("R7");

        // R5: high handler, enable set
        svc = 2'b01; isp = 1'b0; ie = 1'b1;
        pulse(8'h80, 1'b0);
        quiet(5, "R5");
        push(4, 2'b01, "R5");
        pulse(8'h10, 1'b0);
        drain("R5");
        push(0, 2'b11, "R5");
        pulse('0, 1'b1);
        drain("R5");
        svc = 2'b00;
        quiet(3, "R7");
        push(7, 2'b01, "R7");
        retire_one();
        drain("R7");

        // R5: high handler, enable clear
        svc = 2'b01; isp = 1'b0; ie = 1'b0;
        pulse(8'h02, 1'b0);
        quiet(4, "R5");
        push(0, 2'b11, "R5");
        pulse('0, 1'b1);
        drain("R5");
        push(1, 2'b01, "R5");
        ie = 1'b1;
        drain("R5");

        // R6: software handler and low handler accept any level
        svc = 2'b10; isp = 1'b0; ie = 1'b1;
        push(5, 2'b01, "R6");
        pulse(8'h20, 1'b0);
        drain("R6");
        svc = 2'b01; isp = 1'b1;
        push(3, 2'b01, "R6");
        pulse(8'h08, 1'b0);
        drain("R6");
        push(0, 2'b11, "R6");
        pulse('0, 1'b1);
        drain("R6");

        // R6: software handler still honours the enable flag
        svc = 2'b10; ie = 1'b0;
        pulse(8'h04, 1'b0);
        quiet(4, "R6");
        push(2, 2'b01, "R6");
        ie = 1'b1;
        drain("R6");
        quiet(3, "R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule